// File: doc/BRIEF.md
# On-Screen Character Overlay Timing Generator

This block produces the addressing for a character overlay that is laid over an incoming video raster. It runs on the dot clock and locks to the external horizontal and vertical sync. On every dot clock it reports three things: whether the current dot falls inside a character cell, which display-RAM word holds that cell's character code, and which row and column of the 12-by-18 glyph the dot maps to. Downstream glyph and colour logic uses these outputs to fetch pixel colour. The block then gates that colour and drives the fast-blanking enable that switches the screen from the video picture to the overlay.

Software sets the horizontal start offset, a start line for each display-RAM row, one of eight character size modes and a horizontal pitch of 9 to 16 dots. Size modes with 1.5x horizontal magnification make one glyph dot last two clocks and then one clock, in turn. When the pitch is wider than the glyph, the extra dots are blank spacing. When it is narrower, the glyph is cut off at the pitch. Rows may be placed so that they overlap, and the row with the lowest index is then shown. Two polarity inputs select the active level of the sync inputs. Two more select the output polarity of the colour lines and of the blanking line.

Top module: `osd_timing_gen`

## Requirements
- R1: The active edge of HS is a rising edge of hs_in when hs_pol=0 and a falling edge when hs_pol=1. VS is selected the same way by vs_pol. The opposite transition of either input has no effect on any output.
- R2: When a clock edge samples the HS active edge, the dot position is 0 in the following cycle and then counts up by one per cycle. The first active dot of a line is the one whose position equals h_start. Before it, disp_active is 0.
- R3: size_mode selects the horizontal magnification Hm and the vertical magnification V as follows: 0=1x1, 1=1x2, 2=2x2, 3=2x4, 4=1.5x1, 5=1.5x2, 6=3x2, 7=3x4 (Hm x V). Take p as position minus h_start and M as 2·Hm (2, 3, 4 or 6). The glyph dot index is then d = floor(2p/M).
- R4: At 1.5x magnification (size_mode 4 or 5) the dot index goes up by 2 every 3 clocks. The first dot of a line lasts 2 clocks, the next lasts 1, and this repeats.
- R5: The pitch is P = 9 + pitch_sel. Cell column col = d / P, and glyph_col = d mod P.
- R6: A line holds 34 cells. Once col would reach 34, disp_active stays 0 until the next HS active edge.
- R7: ram_addr = row·40 + 6 + col. The 6 control words at the start of each 40-word display-RAM row are never addressed.
- R8: A line counter is set to 0 by the VS active edge and goes up by 1 on each HS active edge. Row r (start line taken from bits [9r+8:9r] of row_start) is displayed on lines start ≤ line < start + 18·V. On those lines glyph_row = floor((line − start)/V).
- R9: When several rows cover the same line, the row with the lowest index is displayed.
- R10: A dot is lit when disp_active=1 and glyph_col < 12. bl_out = lit XOR bl_pol. rgb_out equals rgb_in when the dot is lit and 0 otherwise, with every bit then XORed with rgb_pol.
- R11: Dots whose glyph_col is 12 or more are blank spacing. bl_out and rgb_out stay at their inactive levels for those dots.
- R12: After reset, disp_active=0, bl_out=bl_pol and rgb_out is rgb_pol on every bit. This holds until both an HS and a VS active edge have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_in | input | 1 | Horizontal sync, synchronous to clk |
| vs_in | input | 1 | Vertical sync, synchronous to clk |
| hs_pol | input | 1 | 1 selects falling edge of hs_in as active |
| vs_pol | input | 1 | 1 selects falling edge of vs_in as active |
| h_start | input | 10 | Dot clocks from line start to first cell |
| row_start | input | 36 | Four 9-bit row start lines, row 0 in the low bits |
| size_mode | input | 3 | Character size code (R3) |
| pitch_sel | input | 3 | Pitch code, pitch = 9 + pitch_sel |
| rgb_pol | input | 1 | Inverts all colour outputs |
| bl_pol | input | 1 | Inverts blanking output |
| rgb_in | input | 3 | Pixel colour from glyph/attribute logic |
| disp_active | output | 1 | Current dot lies inside the character grid |
| ram_addr | output | 8 | Display-RAM word of current cell |
| glyph_row | output | 5 | Glyph row index 0..17 |
| glyph_col | output | 4 | Dot index within the pitch |
| bl_out | output | 1 | Fast-blanking enable |
| rgb_out | output | 3 | Gated colour output |

## Verification
The hardest situation to reach from the ports is a long run of 1.5x dots that crosses several cell boundaries while the pitch is not a multiple of the step. The clock-to-dot phase must stay correct across every column, and a single mis-step only shows up tens of cells later. The bench drives full-width lines in every size mode and pitch, both directed and from a seeded random source. It also drives many short lines that end early through a fresh HS edge. These short lines walk the line counter through overlapping row windows cheaply, so the priority and glyph-row scaling get exercised on every line of the frame.

// File: rtl/osd_pkg.sv
package osd_pkg;

  typedef struct packed {
    logic [2:0] m2;
    logic [1:0] vsh;
  } osd_scale_t;

  function automatic osd_scale_t osd_scale_decode(input logic [2:0] mode);
    osd_scale_t s;
    case (mode)
      3'd0:    begin s.m2 = 3'd2; s.vsh = 2'd0; end
      3'd1:    begin s.m2 = 3'd2; s.vsh = 2'd1; end
      3'd2:    begin s.m2 = 3'd4; s.vsh = 2'd1; end
      3'd3:    begin s.m2 = 3'd4; s.vsh = 2'd2; end
      3'd4:    begin s.m2 = 3'd3; s.vsh = 2'd0; end
      3'd5:    begin s.m2 = 3'd3; s.vsh = 2'd1; end
      3'd6:    begin s.m2 = 3'd6; s.vsh = 2'd1; end
      default: begin s.m2 = 3'd6; s.vsh = 2'd2; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic pol,
  output logic act_edge
);
  logic norm, norm_q;

  assign norm = sig_in ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) norm_q <= 1'b1;
    else        norm_q <= norm;
  end

  assign act_edge = norm & ~norm_q;
endmodule

// File: rtl/osd_hscan.sv
module osd_hscan #(
  parameter int HCNT_W    = 11,
  parameter int HSTART_W  = 10,
  parameter int COLS      = 34,
  parameter int PITCH_MIN = 9,
  parameter int COL_W     = $clog2(COLS),
  parameter int DOT_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_edge,
  input  logic [HSTART_W-1:0] h_start,
  input  logic [2:0]          pitch_sel,
  input  logic [2:0]          m2,
  output logic                h_on,
  output logic [COL_W-1:0]    col,
  output logic [DOT_W-1:0]    dcol
);
  logic [HCNT_W-1:0] hcnt;
  logic [2:0]        acc;
  logic [2:0]        acc_sum;
  logic              step;
  logic [DOT_W-1:0]  pitch_m1;
  logic              start_now;

  always_comb begin
    acc_sum   = acc + 3'd2;
    step      = acc_sum >= m2;
    pitch_m1  = DOT_W'(PITCH_MIN - 1) + DOT_W'(pitch_sel);
    start_now = ({1'b0, hcnt} + (HCNT_W+1)'(1)) == (HCNT_W+1)'(h_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '1;
      h_on <= 1'b0;
      acc  <= '0;
      dcol <= '0;
      col  <= '0;
    end else if (line_edge) begin
      hcnt <= '0;
      h_on <= (h_start == '0);
      acc  <= '0;
      dcol <= '0;
      col  <= '0;
    end else begin
      if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (h_on) begin
        if (step) begin
          acc <= acc_sum - m2;
          if (dcol == pitch_m1) begin
            dcol <= '0;
            if (col == COL_W'(COLS - 1)) h_on <= 1'b0;
            else                         col  <= col + 1'b1;
          end else begin
            dcol <= dcol + 1'b1;
          end
        end else begin
          acc <= acc_sum;
        end
      end else if (start_now) begin
        h_on <= 1'b1;
        acc  <= '0;
        dcol <= '0;
        col  <= '0;
      end
    end
  end
endmodule

// File: rtl/osd_vscan.sv
module osd_vscan #(
  parameter int NROWS    = 4,
  parameter int LINE_W   = 10,
  parameter int VSTART_W = 9,
  parameter int GLYPH_H  = 18,
  parameter int ROW_W    = $clog2(NROWS),
  parameter int GROW_W   = $clog2(GLYPH_H)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_edge,
  input  logic                      line_edge,
  input  logic [NROWS*VSTART_W-1:0] row_start,
  input  logic [1:0]                vsh,
  output logic                      v_hit,
  output logic [ROW_W-1:0]          row_idx,
  output logic [GROW_W-1:0]         glyph_row
);
  logic [LINE_W-1:0] vcnt;
  logic [LINE_W-1:0] limit;
  logic [NROWS-1:0]  hit;
  logic [GROW_W-1:0] grow [NROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vcnt <= '1;
    else if (frame_edge) vcnt <= '0;
    else if (line_edge && vcnt != '1) vcnt <= vcnt + 1'b1;
  end

  assign limit = LINE_W'(GLYPH_H) << vsh;

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic [LINE_W-1:0] st;
    logic [LINE_W-1:0] diff;
    logic [LINE_W-1:0] scaled;
    assign st     = LINE_W'(row_start[r*VSTART_W +: VSTART_W]);
    assign diff   = vcnt - st;
    assign scaled = diff >> vsh;
    assign hit[r] = (vcnt >= st) && (diff < limit);
    assign grow[r] = scaled[GROW_W-1:0];
  end

  always_comb begin
    v_hit     = 1'b0;
    row_idx   = '0;
    glyph_row = '0;
    for (int r = NROWS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        v_hit     = 1'b1;
        row_idx   = ROW_W'(r);
        glyph_row = grow[r];
      end
    end
  end
endmodule

// File: rtl/osd_timing_gen.sv
module osd_timing_gen
  import osd_pkg::*;
#(
  parameter int NROWS      = 4,
  parameter int COLS       = 34,
  parameter int CTRL_WORDS = 6,
  parameter int GLYPH_W    = 12,
  parameter int GLYPH_H    = 18,
  parameter int PITCH_MIN  = 9,
  parameter int HCNT_W     = 11,
  parameter int HSTART_W   = 10,
  parameter int LINE_W     = 10,
  parameter int VSTART_W   = 9,
  parameter int ROW_WORDS  = COLS + CTRL_WORDS,
  parameter int ADDR_W     = $clog2(NROWS * ROW_WORDS),
  parameter int GROW_W     = $clog2(GLYPH_H),
  parameter int DOT_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hs_in,
  input  logic                      vs_in,
  input  logic                      hs_pol,
  input  logic                      vs_pol,
  input  logic [HSTART_W-1:0]       h_start,
  input  logic [NROWS*VSTART_W-1:0] row_start,
  input  logic [2:0]                size_mode,
  input  logic [2:0]                pitch_sel,
  input  logic                      rgb_pol,
  input  logic                      bl_pol,
  input  logic [2:0]                rgb_in,
  output logic                      disp_active,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [GROW_W-1:0]         glyph_row,
  output logic [DOT_W-1:0]          glyph_col,
  output logic                      bl_out,
  output logic [2:0]                rgb_out
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(NROWS);

  logic [1:0] raw_sync, sync_pol, sync_edge;
  osd_scale_t scale;
  logic              h_on, v_hit, lit;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row_idx;

  assign raw_sync = {vs_in, hs_in};
  assign sync_pol = {vs_pol, hs_pol};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    osd_sync_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_in   (raw_sync[g]),
      .pol      (sync_pol[g]),
      .act_edge (sync_edge[g])
    );
  end

  assign scale = osd_scale_decode(size_mode);

  osd_hscan #(
    .HCNT_W(HCNT_W), .HSTART_W(HSTART_W), .COLS(COLS),
    .PITCH_MIN(PITCH_MIN), .COL_W(COL_W), .DOT_W(DOT_W)
  ) u_hscan (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_edge (sync_edge[0]),
    .h_start   (h_start),
    .pitch_sel (pitch_sel),
    .m2        (scale.m2),
    .h_on      (h_on),
    .col       (col),
    .dcol      (glyph_col)
  );

  osd_vscan #(
    .NROWS(NROWS), .LINE_W(LINE_W), .VSTART_W(VSTART_W),
    .GLYPH_H(GLYPH_H), .ROW_W(ROW_W), .GROW_W(GROW_W)
  ) u_vscan (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_edge (sync_edge[1]),
    .line_edge  (sync_edge[0]),
    .row_start  (row_start),
    .vsh        (scale.vsh),
    .v_hit      (v_hit),
    .row_idx    (row_idx),
    .glyph_row  (glyph_row)
  );

  always_comb begin
    disp_active = h_on & v_hit;
    lit         = disp_active & (glyph_col < DOT_W'(GLYPH_W));
    ram_addr    = ADDR_W'(row_idx) * ADDR_W'(ROW_WORDS)
                + ADDR_W'(CTRL_WORDS) + ADDR_W'(col);
    bl_out      = lit ^ bl_pol;
    rgb_out     = (lit ? rgb_in : 3'b000) ^ {3{rgb_pol}};
  end
endmodule

// File: rtl/osd_timing_gen_chk.sv
module osd_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_in,
  input logic       vs_in,
  input logic       hs_pol,
  input logic       vs_pol,
  input logic [9:0] h_start,
  input logic [2:0] size_mode,
  input logic [2:0] pitch_sel,
  input logic       rgb_pol,
  input logic       bl_pol,
  input logic       disp_active,
  input logic [7:0] ram_addr,
  input logic [4:0] glyph_row,
  input logic [3:0] glyph_col,
  input logic       bl_out,
  input logic [2:0] rgb_out
);
  logic hs_q, vs_q, hs_rise, vs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hs_in ^ hs_pol;
      vs_q <= vs_in ^ vs_pol;
    end
  end
  assign hs_rise = (hs_in ^ hs_pol) & ~hs_q;
  assign vs_rise = (vs_in ^ vs_pol) & ~vs_q;

  // R2
  start_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && h_start != 10'd0) |=> !disp_active);

  // R3
  dot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active && $past(disp_active) && $stable(ram_addr) && $stable(size_mode)
     && $stable(pitch_sel) && !$past(hs_rise) && !$past(vs_rise))
    |-> (glyph_col == $past(glyph_col) || glyph_col == $past(glyph_col) + 4'd1));

  // R5
  pitch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> ({1'b0, glyph_col} < 5'd9 + {2'b00, pitch_sel}));

  // R7
  ctrl_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> ((ram_addr % 8'd40) >= 8'd6));

  // R8
  grow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> (glyph_row < 5'd18));

  // R11
  bl_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_out != bl_pol) |-> (disp_active && glyph_col < 4'd12));

  // R10
  rgb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_active |-> (rgb_out == {3{rgb_pol}}));
endmodule

bind osd_timing_gen osd_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
  .hs_pol(hs_pol), .vs_pol(vs_pol), .h_start(h_start),
  .size_mode(size_mode), .pitch_sel(pitch_sel), .rgb_pol(rgb_pol),
  .bl_pol(bl_pol), .disp_active(disp_active), .ram_addr(ram_addr),
  .glyph_row(glyph_row), .glyph_col(glyph_col), .bl_out(bl_out),
  .rgb_out(rgb_out)
);

// File: tb/osd_timing_gen_tb.sv
`timescale 1ns/1ps
module osd_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in, vs_in, hs_pol, vs_pol, rgb_pol, bl_pol;
  logic [9:0] h_start;
  logic [35:0] row_start;
  logic [2:0] size_mode, pitch_sel, rgb_in;
  logic       disp_active, bl_out;
  logic [7:0] ram_addr;
  logic [4:0] glyph_row;
  logic [3:0] glyph_col;
  logic [2:0] rgb_out;

  int n_chk = 0;
  int n_fail = 0;
  int vc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .h_start(h_start),
    .row_start(row_start), .size_mode(size_mode), .pitch_sel(pitch_sel),
    .rgb_pol(rgb_pol), .bl_pol(bl_pol), .rgb_in(rgb_in),
    .disp_active(disp_active), .ram_addr(ram_addr), .glyph_row(glyph_row),
    .glyph_col(glyph_col), .bl_out(bl_out), .rgb_out(rgb_out)
  );

  // R3 magnification table in half-units, bench side
  function automatic int hmag2(input int mode);
    case (mode)
      0, 1: return 2;
      2, 3: return 4;
      4, 5: return 3;
      default: return 6;
    endcase
  endfunction

  function automatic int vmag(input int mode);
    case (mode)
      0, 4: return 1;
      3, 7: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d)", req, act, exp, vc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Expected outputs for dot position p on the current line
  task automatic check_pix(input int p);
    int m2, v, pitch, hit, d, col, gcol, grow, st;
    bit hact, act, lit;
    int exp_rgb;
    m2 = hmag2(size_mode);
    v = vmag(size_mode);
    pitch = 9 + pitch_sel;
    hit = -1; grow = 0;
    for (int r = 3; r >= 0; r--) begin
      st = row_start[r*9 +: 9];
      if (vc >= st && vc - st < 18 * v) begin
        hit = r;
        grow = (vc - st) / v;
      end
    end
    hact = 1'b0; col = 0; gcol = 0;
    if (p >= h_start) begin
      d = (2 * (p - h_start)) / m2;
      col = d / pitch;
      gcol = d % pitch;
      hact = (col < 34);
    end
    act = (hit >= 0) && hact;
    lit = act && (gcol < 12);
    chk(disp_active == act, "R2_R6_R8 disp_active", disp_active, act);
    if (act && disp_active) begin
      chk(ram_addr == hit * 40 + 6 + col, "R7_R9 ram_addr", ram_addr, hit * 40 + 6 + col);
      chk(glyph_row == grow, "R8 glyph_row", glyph_row, grow);
      chk(glyph_col == gcol, (m2 == 3) ? "R4 glyph_col" : "R3_R5 glyph_col", glyph_col, gcol);
    end
    chk(bl_out == (lit ^ bl_pol), "R10_R11 bl_out", bl_out, lit ^ bl_pol);
    exp_rgb = (lit ? rgb_in : 0) ^ {3{rgb_pol}};
    chk(rgb_out == exp_rgb[2:0], "R10_R11 rgb_out", rgb_out, exp_rgb);
  endtask

  task automatic run_line(input int len);
    @(negedge clk);
    hs_in = ~hs_pol;
    @(posedge clk);
    vc++;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      if (p == 0) hs_in = hs_pol;
      rgb_in = 3'($urandom);
      #1;
      check_pix(p);
    end
  endtask

  // R1 / R8: VS active edge clears line count; full-width lines every 8th line
  task automatic run_frame(input int nlines);
    int full_len;
    @(negedge clk);
    vs_in = ~vs_pol;
    @(posedge clk);
    vc = 0;
    @(negedge clk);
    vs_in = vs_pol;
    full_len = h_start + (34 * (9 + pitch_sel) * hmag2(size_mode)) / 2 + 6;
    for (int l = 1; l <= nlines; l++) begin
      if (l % 8 == 0) run_line(full_len);
      else            run_line(24);
    end
  endtask

  task automatic set_cfg(input int hp, input int vp, input int hst, input int sm,
                         input int ps, input int rp, input int bp,
                         input int r0, input int r1, input int r2, input int r3);
    @(negedge clk);
    hs_pol = hp[0]; hs_in = hp[0];
    vs_pol = vp[0]; vs_in = vp[0];
    h_start = 10'(hst); size_mode = 3'(sm); pitch_sel = 3'(ps);
    rgb_pol = rp[0]; bl_pol = bp[0];
    row_start = {9'(r3), 9'(r2), 9'(r1), 9'(r0)};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h05D1_2024));
    hs_pol = 0; vs_pol = 0; hs_in = 0; vs_in = 0; rgb_pol = 1; bl_pol = 1;
    h_start = 10'd5; size_mode = 0; pitch_sel = 3; rgb_in = 3'b101;
    row_start = {9'd60, 9'd40, 9'd20, 9'd3};
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(disp_active == 1'b0, "R12 disp_active", disp_active, 0);
    chk(bl_out == 1'b1, "R12 bl_out", bl_out, 1);
    chk(rgb_out == 3'b111, "R12 rgb_out", rgb_out, 7);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(disp_active == 1'b0, "R12 idle after reset", disp_active, 0);

    // 1x1, pitch 12, plain polarity
    set_cfg(0, 0, 5, 0, 3, 0, 0, 3, 20, 40, 60);
    run_frame(56);
    // R4: 1.5x, narrow pitch 9, h_start 0
    set_cfg(0, 0, 0, 4, 0, 0, 1, 0, 8, 26, 44);
    run_frame(56);
    // R1: inverted sync polarity, R9 overlapping rows, 3x4, pitch 16
    set_cfg(1, 1, 17, 7, 7, 1, 1, 10, 4, 20, 20);
    run_frame(56);
    // R5: 1.5x2 with spacing pitch 14, inverted colours
    set_cfg(1, 0, 3, 5, 5, 1, 0, 6, 2, 50, 0);
    run_frame(56);
    // Constrained random frames
    for (int f = 0; f < 4; f++) begin
      set_cfg($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(40, 0),
              $urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(1, 0),
              $urandom_range(1, 0), $urandom_range(50, 0), $urandom_range(50, 0),
              $urandom_range(50, 0), $urandom_range(50, 0));
      run_frame(48);
    end
    done = 1'b1;
    finish_run();
  end
endmodule